// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit controller core, paired with the status register it maintains. Each operation takes an opcode and two operands and produces one result byte. On the same clock edge the block updates the arithmetic flags: carry, half carry, zero and signed overflow. The carry-in for the carrying, borrowing, decimal adjust and rotate-through-carry forms is the stored carry flag. The result also yields a skip condition, which a sequencer uses for skip-if-zero decisions. The status register also holds a sleep flag and a watchdog-expiry flag. Only the system event pins change these two flags. Writes from software through the status write port never touch them.

Operations enter on a valid/ready request channel: `op_valid`, `op_ready`, `op_code`, `op_a` and `op_b`. Results leave on a valid/ready result channel: `res_valid`, `res_ready`, `res_data` and `res_skip`. The result stage holds a single entry. `op_ready` is high when that entry is empty or is being drained in the same cycle. While `res_valid` is high and `res_ready` is low, the result is held unchanged and no new operation is taken. Flags update on the cycle an operation is accepted, so the next accepted operation already sees the new carry. The status write port and the four system event pins are plain single-cycle controls.

Top module: `alu_status_unit`

## Requirements
- R1: ADD (code 0) returns (A+B) mod 256 and ADC (code 1) returns (A+B+C) mod 256. Both set C on a carry out of bit 7, set AC on a carry out of bit 3, and update Z and OV.
- R2: SUB (code 2) returns (A−B) mod 256 and SBC (code 3) returns (A−B−(1−C)) mod 256. C=1 means the full subtraction needed no borrow, and AC=1 means the low nibble needed no borrow. Z and OV are updated as well.
- R3: For ADD, ADC, SUB and SBC, OV (status bit 3) is 1 exactly when the two's-complement result falls outside −128..127.
- R4: Z (status bit 2) is 1 exactly when the 8-bit result is zero. This applies to every operation that updates Z: codes 0–3, 5–8, 13 and 14.
- R5: AND (5), OR (6), XOR (7), CPL (8, returns ~A), INC (13, A+1) and DEC (14, A−1) update only Z. C, AC and OV keep their values.
- R6: RL (9) and RR (10) rotate A left or right by one and change no flag. RLC (11) shifts C into bit 0 and moves bit 7 into C. RRC (12) shifts C into bit 7 and moves bit 0 into C. These rotates change only C.
- R7: DAA (4) acts on A. It adds 06h when A's low nibble exceeds 9 or AC=1. It then adds 60h when the high nibble of that sum exceeds 9, when C=1, or when the first add carried. The result is the low byte. C becomes 1 if the total exceeds FFh, and 0 otherwise. No other flag changes.
- R8: The status output is {0,0,TO,PDF,OV,Z,AC,C}, with bits 7:6 always 0. A write sets bits 3:0 from `st_wr_data[3:0]` and ignores bits 7:4. A write in the same cycle as an accepted operation wins over the operation's flag updates.
- R9: PDF (bit 4) clears on `pwr_up` or `clr_wdt` and is set by `halt`. The clearing events win.
- R10: TO (bit 5) clears on `pwr_up` or `clr_wdt`, is set by `wdt_to`, and clears on `halt`. Priority from highest: `pwr_up` and `clr_wdt`, then `wdt_to`, then `halt`.
- R11: `res_skip` is 1 exactly when `res_data` is zero.
- R12: An operation is accepted when `op_valid` and `op_ready` are both high, and its result is valid on the next cycle. `op_ready` equals `!res_valid || res_ready`. A stalled result keeps its data and skip bit.
- R13: After reset, `status` is 00h, `res_valid` is 0 and `op_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request valid |
| op_ready | output | 1 | Block can take an operation |
| op_code | input | 4 | Operation select (codes in R1–R7) |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| res_valid | output | 1 | Result entry holds data |
| res_ready | input | 1 | Downstream takes the result |
| res_data | output | 8 | Result byte |
| res_skip | output | 1 | Result-is-zero skip condition |
| st_wr_en | input | 1 | Status write strobe |
| st_wr_data | input | 8 | Status write value; only bits 3:0 land |
| pwr_up | input | 1 | Power-up event |
| clr_wdt | input | 1 | Watchdog clear event |
| halt | input | 1 | Halt/sleep event |
| wdt_to | input | 1 | Watchdog time-out event |
| status | output | 8 | Status register contents |

## Verification
The bench builds the block with its default 8-bit data path and 4-bit nibble. At that size every first operand is reachable for every opcode. The arithmetic opcodes each pair A with seventeen second operands, and those pairs cover every carry, half-carry and sign combination. DAA is swept over all 256 inputs under all four C/AC combinations. Before each operation the status write sets the prior C, AC, Z and OV values to rotating patterns and writes bits 7:4 opposite to the sleep and expiry flags. Every sweep step therefore shows which flags each opcode leaves untouched, and that data writes never reach the two system flags.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3,
    OP_DAA = 4'd4,  OP_AND = 4'd5,  OP_OR  = 4'd6,  OP_XOR = 4'd7,
    OP_CPL = 4'd8,  OP_RL  = 4'd9,  OP_RR  = 4'd10, OP_RLC = 4'd11,
    OP_RRC = 4'd12, OP_INC = 4'd13, OP_DEC = 4'd14, OP_NOP = 4'd15
  } alu_op_e;

  // flag positions inside the status word; a sequencer decodes these
  localparam int FB_C   = 0;
  localparam int FB_AC  = 1;
  localparam int FB_Z   = 2;
  localparam int FB_OV  = 3;
  localparam int FB_PDF = 4;
  localparam int FB_TO  = 5;
  localparam int NUM_ARITH_FLAGS = 4;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              c_out,
  output logic              hc_out,
  output logic              ov_out
);
  localparam int NIB_W = DATA_W / 2;

  logic [DATA_W-1:0] opnd;
  logic              ci;
  logic [DATA_W:0]   full;
  logic [NIB_W:0]    low_nib;
  logic [DATA_W-1:0] low_bits;

  // operand conditioning: subtraction is A + ~B + carry
  always_comb begin
    opnd = b;
    ci   = 1'b0;
    unique case (op)
      OP_ADC: ci = cin;
      OP_SUB: begin opnd = ~b; ci = 1'b1; end
      OP_SBC: begin opnd = ~b; ci = cin;  end
      OP_INC: begin opnd = '0; ci = 1'b1; end
      OP_DEC: begin opnd = '1; ci = 1'b0; end
      default: ;
    endcase
  end

  assign full     = {1'b0, a} + {1'b0, opnd} + {{DATA_W{1'b0}}, ci};
  assign low_nib  = {1'b0, a[NIB_W-1:0]} + {1'b0, opnd[NIB_W-1:0]} + {{NIB_W{1'b0}}, ci};
  assign low_bits = {1'b0, a[DATA_W-2:0]} + {1'b0, opnd[DATA_W-2:0]} + {{(DATA_W-1){1'b0}}, ci};

  assign sum    = full[DATA_W-1:0];
  assign c_out  = full[DATA_W];
  assign hc_out = low_nib[NIB_W];
  // carry into the top bit versus carry out of it
  assign ov_out = low_bits[DATA_W-1] ^ full[DATA_W];
endmodule

// File: rtl/alu_decadj.sv
module alu_decadj #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic              cin,
  input  logic              hcin,
  output logic [DATA_W-1:0] res,
  output logic              c_out
);
  localparam int NIB_W = DATA_W / 2;
  localparam logic [NIB_W-1:0] NINE   = NIB_W'(9);
  localparam logic [DATA_W:0]  LO_ADJ = (DATA_W+1)'(6);
  localparam logic [DATA_W:0]  HI_ADJ = (DATA_W+1)'(6) << NIB_W;

  logic            lo_fix, hi_fix;
  logic [DATA_W:0] step1, step2;

  assign lo_fix = (a[NIB_W-1:0] > NINE) || hcin;
  assign step1  = {1'b0, a} + (lo_fix ? LO_ADJ : '0);
  assign hi_fix = (step1[DATA_W-1:NIB_W] > NINE) || cin || step1[DATA_W];
  assign step2  = {1'b0, step1[DATA_W-1:0]} + (hi_fix ? HI_ADJ : '0);

  assign res   = step2[DATA_W-1:0];
  assign c_out = step1[DATA_W] | step2[DATA_W];
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              c_out
);
  always_comb begin
    res   = a;
    c_out = cin;
    unique case (op)
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_CPL: res = ~a;
      OP_RL:  res = {a[DATA_W-2:0], a[DATA_W-1]};
      OP_RR:  res = {a[0], a[DATA_W-1:1]};
      OP_RLC: begin res = {a[DATA_W-2:0], cin}; c_out = a[DATA_W-1]; end
      OP_RRC: begin res = {cin, a[DATA_W-1:1]}; c_out = a[0];        end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu8_pkg::*;
#(
  parameter int ST_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alu_we,
  input  logic [NUM_ARITH_FLAGS-1:0] alu_val,
  input  logic [NUM_ARITH_FLAGS-1:0] alu_msk,
  input  logic                       st_wr_en,
  input  logic [ST_W-1:0]            st_wr_data,
  input  logic                       pwr_up,
  input  logic                       clr_wdt,
  input  logic                       halt,
  input  logic                       wdt_to,
  output logic [ST_W-1:0]            status
);
  localparam logic [ST_W-1:0] WR_MASK = ST_W'((1 << NUM_ARITH_FLAGS) - 1);

  logic [ST_W-1:0] st_q, st_d, alu_merged;

  // per-flag choice between the held value and the ALU's new value
  for (genvar i = 0; i < ST_W; i++) begin : g_merge
    if (i < NUM_ARITH_FLAGS) begin : g_arith
      assign alu_merged[i] = (alu_we && alu_msk[i]) ? alu_val[i] : st_q[i];
    end else begin : g_hold
      assign alu_merged[i] = st_q[i];
    end
  end

  always_comb begin
    st_d = alu_merged;
    if (st_wr_en) st_d = (alu_merged & ~WR_MASK) | (st_wr_data & WR_MASK);
    if (pwr_up || clr_wdt) begin
      st_d[FB_PDF] = 1'b0;
      st_d[FB_TO]  = 1'b0;
    end else begin
      if (halt) st_d[FB_PDF] = 1'b1;
      if (wdt_to)    st_d[FB_TO] = 1'b1;
      else if (halt) st_d[FB_TO] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign status = st_q;

  // R9
  halt_sets_pdf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt && !pwr_up && !clr_wdt |=> status[FB_PDF]);
  // R10
  timeout_sets_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_to && !pwr_up && !clr_wdt |=> status[FB_TO]);
  // R9
  clear_events_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_up || clr_wdt) |=> !status[FB_TO] && !status[FB_PDF]);
  // R8
  sys_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_up || clr_wdt || halt || wdt_to) |=> $stable(status[FB_TO:FB_PDF]));
endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data,
  output logic              res_skip,
  input  logic              st_wr_en,
  input  logic [7:0]        st_wr_data,
  input  logic              pwr_up,
  input  logic              clr_wdt,
  input  logic              halt,
  input  logic              wdt_to,
  output logic [7:0]        status
);
  localparam int ST_W = 8;

  alu_op_e           op;
  logic              accept;
  logic [DATA_W-1:0] as_sum, da_res, bo_res, nxt_res;
  logic              as_c, as_hc, as_ov, da_c, bo_c;
  logic [NUM_ARITH_FLAGS-1:0] fl_val, fl_msk;

  assign op       = alu_op_e'(op_code);
  assign op_ready = !res_valid || res_ready;
  assign accept   = op_valid && op_ready;

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .op(op), .a(op_a), .b(op_b), .cin(status[FB_C]),
    .sum(as_sum), .c_out(as_c), .hc_out(as_hc), .ov_out(as_ov)
  );

  alu_decadj #(.DATA_W(DATA_W)) u_decadj (
    .a(op_a), .cin(status[FB_C]), .hcin(status[FB_AC]),
    .res(da_res), .c_out(da_c)
  );

  alu_bitops #(.DATA_W(DATA_W)) u_bitops (
    .op(op), .a(op_a), .b(op_b), .cin(status[FB_C]),
    .res(bo_res), .c_out(bo_c)
  );

  // result select and per-operation flag update mask
  always_comb begin
    nxt_res = op_a;
    fl_val  = '0;
    fl_msk  = '0;
    fl_val[FB_Z] = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        nxt_res = as_sum;
        fl_val[FB_C] = as_c; fl_val[FB_AC] = as_hc; fl_val[FB_OV] = as_ov;
        fl_msk = '1;
      end
      OP_INC, OP_DEC: begin
        nxt_res = as_sum;
        fl_msk[FB_Z] = 1'b1;
      end
      OP_DAA: begin
        nxt_res = da_res;
        fl_val[FB_C] = da_c;
        fl_msk[FB_C] = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR, OP_CPL: begin
        nxt_res = bo_res;
        fl_msk[FB_Z] = 1'b1;
      end
      OP_RL, OP_RR: nxt_res = bo_res;
      OP_RLC, OP_RRC: begin
        nxt_res = bo_res;
        fl_val[FB_C] = bo_c;
        fl_msk[FB_C] = 1'b1;
      end
      default: ;
    endcase
    fl_val[FB_Z] = (nxt_res == '0);
  end

  alu_flag_reg #(.ST_W(ST_W)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .alu_we(accept), .alu_val(fl_val), .alu_msk(fl_msk),
    .st_wr_en(st_wr_en), .st_wr_data(st_wr_data),
    .pwr_up(pwr_up), .clr_wdt(clr_wdt), .halt(halt), .wdt_to(wdt_to),
    .status(status)
  );

  // single-entry result stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_skip  <= 1'b0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_data  <= nxt_res;
      res_skip  <= fl_val[FB_Z];
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_skip));
  // R12
  accept_gives_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_ready |=> res_valid);
  // R11
  skip_matches_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_skip == (res_data == '0)));
endmodule

// File: tb/sim_alu_status_unit.sv
module sim_alu_status_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0, res_ready = 1'b1, st_wr_en = 1'b0;
  logic pwr_up = 1'b0, clr_wdt = 1'b0, halt = 1'b0, wdt_to = 1'b0;
  logic [3:0] op_code = '0;
  logic [7:0] op_a = '0, op_b = '0, st_wr_data = '0;
  logic op_ready, res_valid, res_skip;
  logic [7:0] res_data, status;

  int n_cmp = 0, n_bad = 0;
  logic [1:0] sys_exp = 2'b00; // {TO, PDF}

  always #2 clk = ~clk;

  alu_status_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_a(op_a), .op_b(op_b), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .res_skip(res_skip),
    .st_wr_en(st_wr_en), .st_wr_data(st_wr_data), .pwr_up(pwr_up),
    .clr_wdt(clr_wdt), .halt(halt), .wdt_to(wdt_to), .status(status)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // reference model from the requirements; fl = {ov,z,ac,c}
  task automatic ref_op(input int op, input int a, input int b, input logic [3:0] pre,
                        output int res, output logic [3:0] fl);
    int ci, t, sr, adj;
    fl = pre;
    res = a;
    case (op)
      0, 1: begin
        ci = (op == 1) ? int'(pre[0]) : 0;
        t = a + b + ci; res = t % 256;
        fl[0] = t > 255;
        fl[1] = ((a % 16) + (b % 16) + ci) > 15;
        sr = sgn(a) + sgn(b) + ci; fl[3] = (sr > 127) || (sr < -128);
        fl[2] = res == 0;
      end
      2, 3: begin
        ci = (op == 3) ? (pre[0] ? 0 : 1) : 0;
        t = a - b - ci; res = (t + 256) % 256;
        fl[0] = t >= 0;
        fl[1] = ((a % 16) - (b % 16) - ci) >= 0;
        sr = sgn(a) - sgn(b) - ci; fl[3] = (sr > 127) || (sr < -128);
        fl[2] = res == 0;
      end
      4: begin
        adj = 0;
        if ((a % 16) > 9 || pre[1]) adj = 6;
        t = a + adj;
        if (((t % 256) / 16) > 9 || pre[0] || t > 255) adj = adj + 96;
        res = (a + adj) % 256; fl[0] = (a + adj) > 255;
      end
      5: begin res = a & b; fl[2] = res == 0; end
      6: begin res = a | b; fl[2] = res == 0; end
      7: begin res = a ^ b; fl[2] = res == 0; end
      8: begin res = 255 - a; fl[2] = res == 0; end
      9:  res = ((a * 2) % 256) + a / 128;
      10: res = (a / 2) + (a % 2) * 128;
      11: begin res = ((a * 2) % 256) + int'(pre[0]); fl[0] = a >= 128; end
      12: begin res = (a / 2) + int'(pre[0]) * 128; fl[0] = (a % 2) == 1; end
      13: begin res = (a + 1) % 256; fl[2] = res == 0; end
      14: begin res = (a + 255) % 256; fl[2] = res == 0; end
      default: ;
    endcase
  endtask

  task automatic run_op(input int op, input int a, input int b, input logic [3:0] pre, input string req);
    int er;
    logic [3:0] ef;
    logic [7:0] est;
    @(negedge clk);
    st_wr_en = 1'b1;
    st_wr_data = {2'b11, ~sys_exp, pre};   // R8: upper bits must not land
    @(negedge clk);
    st_wr_en = 1'b0;
    op_valid = 1'b1; op_code = 4'(op); op_a = 8'(a); op_b = 8'(b);
    @(negedge clk);
    op_valid = 1'b0;
    ref_op(op, a, b, pre, er, ef);
    est = {2'b00, sys_exp, ef};
    check(res_valid === 1'b1, {req, " R12 valid"}, int'(res_valid), 1);
    check(res_data === 8'(er), {req, " result"}, int'(res_data), er);
    check(status === est, {req, " status R8"}, int'(status), int'(est));
    check(res_skip === (er == 0), {req, " R11 skip"}, int'(res_skip), int'(er == 0));
  endtask

  task automatic pulse_evt(input logic pu, input logic cw, input logic hl, input logic wt, input string req);
    @(negedge clk);
    pwr_up = pu; clr_wdt = cw; halt = hl; wdt_to = wt;
    if (pu || cw) sys_exp = 2'b00;
    else begin
      if (hl) sys_exp[0] = 1'b1;
      if (wt) sys_exp[1] = 1'b1;
      else if (hl) sys_exp[1] = 1'b0;
    end
    @(negedge clk);
    pwr_up = 0; clr_wdt = 0; halt = 0; wdt_to = 0;
    check(status[5:4] === sys_exp, req, int'(status[5:4]), int'(sys_exp));
    check(status[7:6] === 2'b00, "R8 upper bits zero", int'(status[7:6]), 0);
  endtask

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    check(status === 8'h00, "R13 status", int'(status), 0);
    check(res_valid === 1'b0, "R13 res_valid", int'(res_valid), 0);
    check(op_ready === 1'b1, "R13 op_ready", int'(op_ready), 1);
    rst_n = 1'b1;

    // R9 / R10 system events and priorities
    pulse_evt(0, 0, 1, 0, "R9 halt sets PDF");
    pulse_evt(0, 0, 0, 1, "R10 timeout sets TO");
    pulse_evt(0, 0, 1, 0, "R10 halt clears TO");
    pulse_evt(0, 1, 0, 0, "R9 clr_wdt clears");
    pulse_evt(0, 0, 1, 1, "R10 timeout beats halt");
    pulse_evt(0, 1, 1, 1, "R9 clr_wdt beats halt");
    pulse_evt(0, 0, 0, 1, "R10 timeout alone");
    pulse_evt(1, 0, 1, 0, "R9 pwr_up clears");
    pulse_evt(0, 0, 1, 1, "R10 both set");

    // R1 R2 R3 R4 arithmetic sweep
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < 256; a++)
        for (int bi = 0; bi < 17; bi++)
          run_op(op, a, (bi == 16) ? a : bi * 17, 4'((a + bi) % 16),
                 (op < 2) ? "R1 R3 R4 add" : "R2 R3 R4 sub");

    pulse_evt(0, 1, 0, 0, "R9 clear before unary sweep");
    // R7 decimal adjust
    for (int a = 0; a < 256; a++)
      for (int p = 0; p < 4; p++)
        run_op(4, a, 0, 4'((a % 4) * 4 + p), "R7 daa");
    // R5 R6 logic, rotate, inc/dec
    for (int op = 5; op < 15; op++)
      for (int a = 0; a < 256; a++)
        run_op(op, a, (a * 7 + 93) % 256, 4'((a + op) % 16),
               (op >= 9 && op <= 12) ? "R6 rotate" : "R5 Z-only");

    // R8 write wins over a same-cycle operation
    @(negedge clk);
    st_wr_en = 1'b1; st_wr_data = 8'h00;
    op_valid = 1'b1; op_code = 4'd0; op_a = 8'hFF; op_b = 8'h01;
    @(negedge clk);
    st_wr_en = 1'b0; op_valid = 1'b0;
    check(status[3:0] === 4'h0, "R8 write beats op", int'(status[3:0]), 0);
    check(res_data === 8'h00, "R1 wrap result", int'(res_data), 0);

    // R12 back-pressure
    @(negedge clk);
    res_ready = 1'b0; op_valid = 1'b1; op_code = 4'd0; op_a = 8'd1; op_b = 8'd2;
    @(negedge clk);
    check(res_data === 8'd3 && res_valid, "R12 first result", int'(res_data), 3);
    check(op_ready === 1'b0, "R12 ready low when full", int'(op_ready), 0);
    op_a = 8'd5; op_b = 8'd5;
    @(negedge clk);
    check(res_data === 8'd3, "R12 held under stall", int'(res_data), 3);
    check(op_ready === 1'b0, "R12 still stalled", int'(op_ready), 0);
    res_ready = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    check(res_data === 8'd10 && res_valid, "R12 second accepted", int'(res_data), 10);
    @(negedge clk);
    check(res_valid === 1'b0, "R12 drained", int'(res_valid), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule